// File: doc/BRIEF.md
# Supervisor Reset Sequencer

This block turns the digital results of a supply monitor and a manual reset pin into one active-low system reset. The supply monitor delivers two synchronous flags: one saying the supply has dropped below the falling threshold, the other saying it has climbed above the falling threshold plus hysteresis. The manual reset pin is asynchronous and active low. It has a pull-up, so an undriven pin reads as released. Reset asserts as soon as any fault appears. It is released only after every fault has cleared and a full, parameterised delay has run without a new fault.

After every reset event, and once the supply is above the falling threshold, the block runs a bounded evaluation phase. In that phase it samples a sensed two-bit strap code that describes the watchdog timing pin (floating, pulled up, or wired to an external timing element) and latches the resulting watchdog timing mode. Two of the modes pick fixed preset window timings. The third tells the watchdog to use a programmable upper bound. A watchdog-permit flag goes high only when reset is released and the evaluation has finished. While manual reset is held, the flag stays low, so the watchdog heartbeat is ignored.

Top module: `supervisor_reset_seq`

## Requirements
- R1: A cycle in which `uv_below` is sampled high drives `rst_out_n` low at that clock edge, whatever `uv_release` shows in the same cycle.
- R2: After `uv_below` has been high, reset stays asserted for as long as `uv_release` has not been seen high (hysteresis), even with `uv_below` low.
- R3: Once all faults are clear, `rst_out_n` rises at the RST_DELAY-th consecutive fault-free clock edge and not before.
- R4: A fault that appears while the delay is counting restarts the count from zero, so release comes RST_DELAY fault-free edges after the last fault.
- R5: `mr_n` passes through a two-flop synchroniser and a low-level filter. If it is held low for MR_MIN cycles, `rst_out_n` falls MR_MIN+3 edges after it went low. A low pulse of MR_MIN-1 cycles has no effect.
- R6: After a filtered manual reset, `rst_out_n` rises RST_DELAY+3 edges after `mr_n` returns high, provided the supply is good.
- R7: An evaluation starts from the power-on reset state, and is restarted by `uv_below` high or by an active manual reset. Once those clear, `mode_sel` is sampled and latched into `wd_mode` at the EVAL_CYCLES+1-th edge.
- R8: The strap code `mode_sel` is mapped to `wd_mode` as follows:
  - 2'b00 (floating) gives 2'b00 (long preset window).
  - 2'b01 (pulled up) gives 2'b01 (short preset window).
  - 2'b10 (external timing element) gives 2'b10 (programmable upper bound).
  - 2'b11 (unresolved) gives 2'b00.
- R9: `wd_mode` holds its value between evaluations. Changes on `mode_sel` outside the evaluation window have no effect.
- R10: No evaluation completes while `uv_below` is high or manual reset is active, and `wd_mode` keeps its previous value during that time.
- R11: `wd_allow` is high only when `rst_out_n` is high and the latest evaluation has completed. It is low whenever manual reset holds reset.
- R12: While `rst_n` is low, `rst_out_n` is 0, `wd_mode` is 2'b00 and `wd_allow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset of the logic, active low |
| uv_below | input | 1 | Supply below falling threshold (synchronous) |
| uv_release | input | 1 | Supply above falling threshold plus hysteresis (synchronous) |
| mr_n | input | 1 | Manual reset pin, active low, asynchronous |
| mode_sel | input | 2 | Sensed timing-pin strap code |
| rst_out_n | output | 1 | System reset, active low |
| wd_mode | output | 2 | Latched watchdog timing mode |
| wd_allow | output | 1 | Watchdog permitted to run |

## Verification
Results are due at fixed latencies:
- A supply fault shows on `rst_out_n` one edge after it is sampled.
- Supply release lands on the RST_DELAY-th fault-free edge.
- A manual reset adds three edges for synchronisation and filtering: MR_MIN+3 edges to assert and RST_DELAY+3 edges to release.
- A mode latch lands EVAL_CYCLES+1 edges after the restart source clears.

Each directed task changes inputs on a falling clock edge and counts falling edges before sampling. Each latency is checked on both sides: the result must be absent one edge before it is due and present on the edge it is due.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        WMODE_PRESET_LONG  = 2'b00,
        WMODE_PRESET_SHORT = 2'b01,
        WMODE_EXTERNAL     = 2'b10
    } wmode_e;

    typedef enum logic [1:0] {
        STRAP_FLOAT    = 2'b00,
        STRAP_PULLUP   = 2'b01,
        STRAP_EXTERNAL = 2'b10,
        STRAP_UNKNOWN  = 2'b11
    } strap_e;

    typedef enum logic [1:0] {
        DET_WAIT = 2'b00,
        DET_EVAL = 2'b01,
        DET_DONE = 2'b10
    } det_state_e;

    function automatic wmode_e strap_to_mode(input logic [1:0] code);
        wmode_e m;
        case (code)
            STRAP_PULLUP:   m = WMODE_PRESET_SHORT;
            STRAP_EXTERNAL: m = WMODE_EXTERNAL;
            default:        m = WMODE_PRESET_LONG;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sup_mr_filter.sv
module sup_mr_filter #(
    parameter int MR_MIN = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_n,
    output logic mr_active
);
    localparam int CW = (MR_MIN > 1) ? $clog2(MR_MIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(MR_MIN - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] lowcnt;
        logic          active;
    } mrf_t;

    mrf_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = mr_n;
        st_d.s2 = st_q.s1;
        if (st_q.s2) begin
            st_d.lowcnt = '0;
            st_d.active = 1'b0;
        end else begin
            if (st_q.lowcnt != LAST) begin
                st_d.lowcnt = st_q.lowcnt + 1'b1;
            end
            st_d.active = st_q.active || (st_q.lowcnt == LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, lowcnt: '0, active: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mr_active = st_q.active;

    // R5: the filter may only become active after a synchronised low sample
    assert_mr_rise_needs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> $past(!st_q.s2));

    // R6: a high synchronised sample clears the filter at the next edge
    assert_mr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s2 |=> !st_q.active);

endmodule

// File: rtl/sup_delay_ctrl.sv
module sup_delay_ctrl #(
    parameter int RST_DELAY = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_below,
    input  logic uv_release,
    input  logic mr_active,
    output logic rst_out_n
);
    localparam int CW = $clog2(RST_DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_DELAY - 1);

    typedef struct packed {
        logic          supply_ok;
        logic [CW-1:0] cnt;
        logic          rel;
    } dly_t;

    dly_t st_d, st_q;
    logic fault;

    always_comb begin
        st_d = st_q;
        // falling-threshold flag wins over the release flag
        if (uv_below) begin
            st_d.supply_ok = 1'b0;
        end else if (uv_release) begin
            st_d.supply_ok = 1'b1;
        end
        fault = !st_d.supply_ok || mr_active;
        if (fault) begin
            st_d.cnt = '0;
            st_d.rel = 1'b0;
        end else if (!st_q.rel) begin
            if (st_q.cnt == LAST) begin
                st_d.rel = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{supply_ok: 1'b0, cnt: '0, rel: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_out_n = st_q.rel;

    // R1: falling-threshold flag pulls reset low at the next edge
    assert_uv_asserts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        uv_below |=> !rst_out_n);

    // R2: release is only possible with the hysteresis latch set
    assert_release_needs_hyst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> st_q.supply_ok);

    // R3: the counter has reached its end value when reset is released
    assert_release_after_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(st_q.cnt == LAST));

    // R4: any fault returns the counter to zero
    assert_fault_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_below || mr_active) |=> (st_q.cnt == '0));

endmodule

// File: rtl/sup_mode_detect.sv
module sup_mode_detect
    import sup_pkg::*;
#(
    parameter int EVAL_CYCLES = 95_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] mode_sel,
    output logic [1:0] wd_mode,
    output logic       done
);
    localparam int CW = (EVAL_CYCLES > 1) ? $clog2(EVAL_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(EVAL_CYCLES - 1);

    typedef struct packed {
        det_state_e    state;
        logic [CW-1:0] cnt;
        wmode_e        mode;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.state = DET_WAIT;
            st_d.cnt   = '0;
        end else begin
            case (st_q.state)
                DET_WAIT: begin
                    st_d.state = DET_EVAL;
                    st_d.cnt   = '0;
                end
                DET_EVAL: begin
                    if (st_q.cnt == LAST) begin
                        st_d.state = DET_DONE;
                        st_d.mode  = strap_to_mode(mode_sel);
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d.state = DET_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: DET_WAIT, cnt: '0, mode: WMODE_PRESET_LONG};
        end else begin
            st_q <= st_d;
        end
    end

    assign wd_mode = st_q.mode;
    assign done    = (st_q.state == DET_DONE);

    // R9: outside evaluation the latched mode does not move
    assert_mode_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state != DET_EVAL) |=> $stable(st_q.mode));

    // R10: a restart source prevents completion
    assert_restart_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !done);

    // R7: completion always follows an evaluation phase
    assert_done_from_eval_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(st_q.state == DET_EVAL));

endmodule

// File: rtl/supervisor_reset_seq.sv
module supervisor_reset_seq #(
    parameter int RST_DELAY   = 50_000_000,
    parameter int MR_MIN      = 200,
    parameter int EVAL_CYCLES = 95_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uv_below,
    input  logic       uv_release,
    input  logic       mr_n,
    input  logic [1:0] mode_sel,
    output logic       rst_out_n,
    output logic [1:0] wd_mode,
    output logic       wd_allow
);
    logic mr_active;
    logic det_done;
    logic det_restart;

    sup_mr_filter #(.MR_MIN(MR_MIN)) u_mr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mr_n      (mr_n),
        .mr_active (mr_active)
    );

    sup_delay_ctrl #(.RST_DELAY(RST_DELAY)) u_dly (
        .clk        (clk),
        .rst_n      (rst_n),
        .uv_below   (uv_below),
        .uv_release (uv_release),
        .mr_active  (mr_active),
        .rst_out_n  (rst_out_n)
    );

    assign det_restart = uv_below || mr_active;

    sup_mode_detect #(.EVAL_CYCLES(EVAL_CYCLES)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (det_restart),
        .mode_sel (mode_sel),
        .wd_mode  (wd_mode),
        .done     (det_done)
    );

    assign wd_allow = rst_out_n && det_done;

    // R11: the watchdog is never permitted while manual reset is active
    assert_no_wd_in_mr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mr_active |=> !wd_allow);

    // R12: outputs are in their idle state right after power-on reset
    assert_reset_state_R12: assert property (@(posedge clk)
        !rst_n |-> (!rst_out_n && !wd_allow && wd_mode == 2'b00));

endmodule

// File: tb/supervisor_reset_seq_tb_top.sv
`timescale 1ns/1ps
module supervisor_reset_seq_tb_top;
    localparam int RST_DELAY   = 40;
    localparam int MR_MIN      = 5;
    localparam int EVAL_CYCLES = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uv_below = 1'b0;
    logic       uv_release = 1'b0;
    logic       mr_n = 1'b1;
    logic [1:0] mode_sel = 2'b01;
    logic       rst_out_n;
    logic [1:0] wd_mode;
    logic       wd_allow;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    supervisor_reset_seq #(
        .RST_DELAY(RST_DELAY), .MR_MIN(MR_MIN), .EVAL_CYCLES(EVAL_CYCLES)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .uv_below(uv_below), .uv_release(uv_release),
        .mr_n(mr_n), .mode_sel(mode_sel), .rst_out_n(rst_out_n),
        .wd_mode(wd_mode), .wd_allow(wd_allow)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        edges(3);
        check("R12 rst_out_n", rst_out_n, 0);
        check("R12 wd_mode", wd_mode, 0);
        check("R12 wd_allow", wd_allow, 0);
    endtask

    task automatic t_power_on();
        rst_n = 1'b1;
        edges(EVAL_CYCLES);
        check("R7 mode before latch", wd_mode, 0);
        edges(1);
        check("R8 pulled-up mode", wd_mode, 1);
        edges(80);
        check("R2 held without release flag", rst_out_n, 0);
        check("R11 no allow in reset", wd_allow, 0);
        uv_release = 1'b1;
        edges(RST_DELAY - 1);
        check("R3 not yet released", rst_out_n, 0);
        edges(1);
        check("R3 released", rst_out_n, 1);
        check("R11 allow after release", wd_allow, 1);
    endtask

    task automatic t_uv_fault();
        uv_below = 1'b1;
        uv_release = 1'b1;
        edges(1);
        check("R1 uv asserts reset", rst_out_n, 0);
        uv_release = 1'b0;
        mode_sel = 2'b10;
        edges(50);
        check("R10 mode kept during fault", wd_mode, 1);
        uv_below = 1'b0;
        edges(EVAL_CYCLES);
        check("R7 mode before latch", wd_mode, 1);
        edges(1);
        check("R8 external mode", wd_mode, 2);
        edges(30);
        check("R2 hysteresis holds reset", rst_out_n, 0);
        uv_release = 1'b1;
        edges(RST_DELAY);
        check("R3 released after uv", rst_out_n, 1);
    endtask

    task automatic t_restart();
        uv_below = 1'b1;
        edges(1);
        uv_below = 1'b0;
        edges(20);
        check("R4 mid count low", rst_out_n, 0);
        uv_below = 1'b1;
        edges(1);
        uv_below = 1'b0;
        edges(RST_DELAY - 1);
        check("R4 count restarted", rst_out_n, 0);
        edges(1);
        check("R4 release after restart", rst_out_n, 1);
        check("R11 allow after restart", wd_allow, 1);
    endtask

    task automatic t_mr_short();
        mr_n = 1'b0;
        edges(MR_MIN - 1);
        mr_n = 1'b1;
        edges(12);
        check("R5 short pulse ignored", rst_out_n, 1);
        check("R5 allow kept", wd_allow, 1);
    endtask

    task automatic t_mr_long();
        mode_sel = 2'b11;
        mr_n = 1'b0;
        edges(MR_MIN + 2);
        check("R5 before filter", rst_out_n, 1);
        edges(1);
        check("R5 manual reset asserted", rst_out_n, 0);
        check("R11 allow off in manual reset", wd_allow, 0);
        edges(20);
        check("R10 mode kept in manual reset", wd_mode, 2);
        mr_n = 1'b1;
        edges(RST_DELAY + 2);
        check("R6 not yet released", rst_out_n, 0);
        edges(1);
        check("R6 released", rst_out_n, 1);
        check("R8 unresolved code maps to long", wd_mode, 0);
    endtask

    task automatic t_mode_hold();
        mode_sel = 2'b01;
        edges(30);
        check("R9 mode held", wd_mode, 0);
        check("R9 reset stays released", rst_out_n, 1);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_power_on();
        t_uv_fault();
        t_restart();
        t_mr_short();
        t_mr_long();
        t_mode_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule